// File: doc/BRIEF.md
# SD Single-Line Data Block Engine

This engine carries fixed-size data blocks between a 32-bit host bus and the single data line of an SD card. Each block is 4096 bits, which is 128 words of 32 bits. Two separate buffers hold the words, one for transmit and one for receive. A single-cycle strobe, `bit_tick`, paces the engine at one card bit per strobe. Command issuing and card clock generation are done by neighbouring logic.

For a write, the host, or a DMA engine driven by `tx_dreq`, fills the transmit buffer. The engine then shifts the block out with framing and a CRC16. It decodes the card's three-bit status token and waits for the card to leave its busy state. For a read, the engine waits a bounded time for a start bit, then packs the incoming bits into words for the receive buffer. A DMA engine driven by `rx_dreq`, or the host, drains that buffer. At the end of each transfer the engine gives a one-cycle `done` pulse and holds a result code on `status`.

Top module: `sd_dat_engine`

## Requirements
- R1: The transmit buffer holds up to 128 words. A `tx_wr` write is stored when the buffer is not full and is ignored when it is full. `tx_dreq` is 1 exactly while fewer than 128 words are held.
- R2: The receive buffer is first in, first out. `rx_rdata` shows the oldest unread word, and `rx_rd` removes it. `rx_dreq` is 1 exactly while at least one unread word is held.
- R3: `start_wr` is accepted only when the engine is idle and the transmit buffer is full. `start_rd` is accepted only when the engine is idle and the receive buffer is empty. Any other start pulse is ignored, and `busy` stays 0.
- R4: A write drives the following on successive ticks, with `dat_oe` = 1: a start bit of 0, the 4096 data bits, 16 CRC bits, and an end bit of 1. Words go out in buffer order, and bit 31 of each word goes first (most significant byte first, most significant bit first). `dat_oe` returns to 0 on the tick after the end bit.
- R5: The CRC is CRC16 with polynomial x^16+x^12+x^5+1 (0x1021). It starts from zero, covers the data bits only, and is sent most significant bit first.
- R6: After a write, the engine waits for a 0 start bit on `dat_in` and then takes the next three bits as the status token, first bit most significant. Token 010 gives status 0 (ok), 101 gives status 1 (CRC error), and any other value gives status 2 (token error). The bit after the token is not examined.
- R7: After the token, `dat_in` = 0 means the card is busy. `done` rises only after the first tick on which `dat_in` is sampled as 1, and `busy` stays 1 until then.
- R8: If `dat_in` is sampled low for more than `busy_limit` consecutive ticks while the card is busy, the write ends with status 3. The same status results if `dat_in` is sampled high for more than `busy_limit` consecutive ticks while waiting for the token.
- R9: A read that samples `dat_in` high for more than `rd_limit` consecutive ticks without seeing a start bit ends with status 4.
- R10: A read packs the 4096 bits after the start bit into words, with the first bit received placed in bit 31. It pushes each completed word into the receive buffer.
- R11: A read compares the 16 received CRC bits with the CRC16 of the data and requires an end bit of 1. A CRC mismatch or a bad end bit gives status 1; otherwise the status is 0.
- R12: `done` is a one-cycle pulse, and `status` holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One card bit period elapses |
| dat_in | input | 1 | Data line as sampled from the card |
| dat_out | output | 1 | Data line value driven to the card |
| dat_oe | output | 1 | Output enable for the data line |
| tx_wr | input | 1 | Write one word into the transmit buffer |
| tx_wdata | input | 32 | Transmit word |
| tx_dreq | output | 1 | Transmit buffer has free room |
| rx_rd | input | 1 | Remove the oldest receive word |
| rx_rdata | output | 32 | Oldest receive word |
| rx_dreq | output | 1 | Receive buffer holds unread words |
| start_wr | input | 1 | Begin a block write |
| start_rd | input | 1 | Begin a block read |
| busy_limit | input | 16 | Bound on token wait and busy wait, in ticks |
| rd_limit | input | 16 | Bound on read start-bit wait, in ticks |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished (one cycle) |
| status | output | 3 | Result: 0 ok, 1 CRC or framing error, 2 token error, 3 busy timeout, 4 read timeout |

## Verification
If a buffer pointer or counter is corrupted, the fault shows at the ports within one word time. A transmitted word arrives out of order or repeated on `dat_out`, or a received word reads back wrong on `rx_rdata`. A `tx_dreq` or `rx_dreq` level that disagrees with the number of words written or read is seen in the cycle after the access. A bad CRC register or a bit counter that is off by one shows in the 16 check bits or in the end bit of a written block. On a read, the same faults turn a clean block into status 1. A wrong token decode, or a wrong timeout compare, shows as a wrong `status` value or as a `done` pulse one tick early or late at the close of the transfer.

// File: rtl/sd_dat_engine.sv
module sd_dat_engine #(
  parameter int DEPTH = 128,
  parameter int TO_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_tick,
  input  logic            dat_in,
  output logic            dat_out,
  output logic            dat_oe,
  input  logic            tx_wr,
  input  logic [31:0]     tx_wdata,
  output logic            tx_dreq,
  input  logic            rx_rd,
  output logic [31:0]     rx_rdata,
  output logic            rx_dreq,
  input  logic            start_wr,
  input  logic            start_rd,
  input  logic [TO_W-1:0] busy_limit,
  input  logic [TO_W-1:0] rd_limit,
  output logic            busy,
  output logic            done,
  output logic [2:0]      status
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NBITS = DEPTH * 32;
  localparam int BW    = $clog2(NBITS);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [BW-1:0] LAST = BW'(NBITS - 1);
  localparam logic [2:0] ST_OK = 3'd0, ST_CRC = 3'd1, ST_TOK = 3'd2, ST_BTO = 3'd3, ST_RTO = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_WSTART, S_WDATA, S_WCRC, S_WEND, S_WTOK, S_WTB, S_WTE, S_WBUSY,
    S_RWAIT, S_RDATA, S_RCRC, S_REND
  } state_t;

  state_t          st;
  logic [BW-1:0]   cnt;
  logic [TO_W-1:0] tmr;
  logic [31:0]     sh;
  logic [15:0]     crc;
  logic [2:0]      tok;
  logic            bad;

  logic [31:0]   txm [DEPTH];
  logic [31:0]   rxm [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  wire [31:0] rx_word = {sh[30:0], dat_in};
  wire tx_push = tx_wr && (tx_cnt != FULL);
  wire tx_pop  = bit_tick && ((st == S_WSTART) ||
                 (st == S_WDATA && cnt[4:0] == 5'd31 && cnt != LAST));
  wire rx_push = bit_tick && (st == S_RDATA) && (cnt[4:0] == 5'd31);
  wire rx_pop  = rx_rd && (rx_cnt != '0);
  wire [2:0] tok_code = (tok == 3'b010) ? ST_OK : (tok == 3'b101) ? ST_CRC : ST_TOK;

  assign tx_dreq  = tx_cnt != FULL;
  assign rx_dreq  = rx_cnt != '0;
  assign rx_rdata = rxm[rx_rp];
  assign busy     = st != S_IDLE;

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp] <= tx_wdata;
    if (rx_push) rxm[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + AW'(1);
      if (tx_pop)  tx_rp <= tx_rp + AW'(1);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + AW'(1);
      if (rx_pop)  rx_rp <= rx_rp + AW'(1);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; tmr <= '0; sh <= '0; crc <= '0; tok <= '0; bad <= 1'b0;
      dat_out <= 1'b1; dat_oe <= 1'b0; done <= 1'b0; status <= ST_OK;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start_wr && tx_cnt == FULL) st <= S_WSTART;
        else if (start_rd && rx_cnt == '0) begin st <= S_RWAIT; tmr <= '0; end
      end else if (bit_tick) begin
        case (st)
          S_WSTART: begin
            dat_out <= 1'b0; dat_oe <= 1'b1; sh <= txm[tx_rp]; crc <= '0; cnt <= '0; st <= S_WDATA;
          end
          S_WDATA: begin
            dat_out <= sh[31];
            crc <= crc_step(crc, sh[31]);
            sh <= (cnt[4:0] == 5'd31) ? txm[tx_rp] : {sh[30:0], 1'b0};
            cnt <= (cnt == LAST) ? '0 : cnt + BW'(1);
            if (cnt == LAST) st <= S_WCRC;
          end
          S_WCRC: begin
            dat_out <= crc[15]; crc <= {crc[14:0], 1'b0}; cnt <= cnt + BW'(1);
            if (cnt == BW'(15)) st <= S_WEND;
          end
          S_WEND: begin dat_out <= 1'b1; tmr <= '0; st <= S_WTOK; end
          S_WTOK: begin
            dat_oe <= 1'b0;
            if (!dat_in) begin st <= S_WTB; cnt <= '0; end
            else if (tmr == busy_limit) begin st <= S_IDLE; done <= 1'b1; status <= ST_BTO; end
            else tmr <= tmr + TO_W'(1);
          end
          S_WTB: begin
            tok <= {tok[1:0], dat_in}; cnt <= cnt + BW'(1);
            if (cnt == BW'(2)) st <= S_WTE;
          end
          S_WTE: begin tmr <= '0; st <= S_WBUSY; end
          S_WBUSY: begin
            if (dat_in) begin st <= S_IDLE; done <= 1'b1; status <= tok_code; end
            else if (tmr == busy_limit) begin st <= S_IDLE; done <= 1'b1; status <= ST_BTO; end
            else tmr <= tmr + TO_W'(1);
          end
          S_RWAIT: begin
            if (!dat_in) begin st <= S_RDATA; cnt <= '0; crc <= '0; end
            else if (tmr == rd_limit) begin st <= S_IDLE; done <= 1'b1; status <= ST_RTO; end
            else tmr <= tmr + TO_W'(1);
          end
          S_RDATA: begin
            sh <= rx_word; crc <= crc_step(crc, dat_in);
            cnt <= (cnt == LAST) ? '0 : cnt + BW'(1);
            if (cnt == LAST) st <= S_RCRC;
          end
          S_RCRC: begin
            sh <= rx_word; cnt <= cnt + BW'(1);
            if (cnt == BW'(15)) begin bad <= rx_word[15:0] != crc; st <= S_REND; end
          end
          S_REND: begin
            st <= S_IDLE; done <= 1'b1; status <= (bad || !dat_in) ? ST_CRC : ST_OK;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r1_tx_bound: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= FULL);
  a_r1_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_cnt == FULL && !tx_pop) |=> tx_cnt == FULL);
  a_r2_rx_bound: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= FULL);
  a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n) $rose(dat_oe) |-> !dat_out);
  a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n) (st == S_IDLE) |-> !dat_oe);
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r12_status_held: assert property (@(posedge clk) disable iff (!rst_n) !done |=> $stable(status) || done);
endmodule

// File: tb/sd_dat_engine_tb.sv
module sd_dat_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0, dat_in = 1'b1;
  logic tx_wr = 1'b0, rx_rd = 1'b0, start_wr = 1'b0, start_rd = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic [15:0] busy_limit = 16'd5, rd_limit = 16'd10;
  logic dat_out, dat_oe, tx_dreq, rx_dreq, busy, done;
  logic [31:0] rx_rdata;
  logic [2:0] status;
  int checks = 0, fails = 0;
  logic [31:0] wd [128];

  always #2 clk = ~clk;

  sd_dat_engine u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tk(input logic b);
    @(negedge clk); dat_in = b; bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
  endtask

  function automatic logic [15:0] crc_of_block();
    logic [15:0] c = '0;
    for (int k = 0; k < 4096; k++) begin
      logic b = wd[k/32][31 - (k%32)];
      c = {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0);
    end
    return c;
  endfunction

  task automatic do_write(input logic [2:0] tokv, input int gap, input int blen, input logic [2:0] exp, input bit extra);
    int err = 0, cerr = 0, early = 0;
    logic [15:0] c;
    for (int i = 0; i < 128; i++) begin
      wd[i] = $urandom;
      @(negedge clk); tx_wr = 1'b1; tx_wdata = wd[i];
    end
    @(negedge clk); tx_wr = 1'b0;
    chk(tx_dreq == 1'b0, "R1 dreq low when full", tx_dreq, 0);
    if (extra) begin
      @(negedge clk); tx_wr = 1'b1; tx_wdata = 32'hDEADBEEF;
      @(negedge clk); tx_wr = 1'b0;
    end
    c = crc_of_block();
    @(negedge clk); start_wr = 1'b1;
    @(negedge clk); start_wr = 1'b0;
    tk(1'b1);
    chk(dat_oe && !dat_out, "R4 start bit", {dat_oe, dat_out}, 2'b10);
    for (int k = 0; k < 4096; k++) begin
      tk(1'b1);
      if (!dat_oe || dat_out != wd[k/32][31 - (k%32)]) err++;
    end
    chk(err == 0, extra ? "R4 R1 data bits (full write ignored)" : "R4 data bits", err, 0);
    for (int j = 0; j < 16; j++) begin
      tk(1'b1);
      if (!dat_oe || dat_out != c[15-j]) cerr++;
    end
    chk(cerr == 0, "R5 crc bits", cerr, 0);
    tk(1'b1);
    chk(dat_oe && dat_out, "R4 end bit", {dat_oe, dat_out}, 2'b11);
    chk(tx_dreq == 1'b1, "R1 dreq high after drain", tx_dreq, 1);
    for (int g = 0; g < gap; g++) tk(1'b1);
    tk(1'b0);
    chk(dat_oe == 1'b0, "R4 line released", dat_oe, 0);
    tk(tokv[2]); tk(tokv[1]); tk(tokv[0]); tk(1'b1);
    for (int i = 0; i < blen; i++) begin
      tk(1'b0);
      if (i < blen - 1 || exp != 3'd3) if (done || !busy) early++;
    end
    chk(early == 0, "R7 held busy", early, 0);
    if (exp != 3'd3) tk(1'b1);
    chk(done && status == exp, exp == 3'd3 ? "R8 busy timeout" : "R6 R7 token status", {done, status}, {1'b1, exp});
    @(negedge clk);
    chk(!done && status == exp, "R12 pulse and hold", {done, status}, {1'b0, exp});
    dat_in = 1'b1;
  endtask

  task automatic do_read(input int mode, input int gap);
    logic [15:0] c;
    int err = 0;
    logic [2:0] exp = (mode == 0) ? 3'd0 : 3'd1;
    for (int i = 0; i < 128; i++) wd[i] = $urandom;
    c = crc_of_block();
    if (mode == 1) c[0] = ~c[0];
    @(negedge clk); start_rd = 1'b1;
    @(negedge clk); start_rd = 1'b0;
    for (int g = 0; g < gap; g++) tk(1'b1);
    tk(1'b0);
    for (int k = 0; k < 4096; k++) tk(wd[k/32][31 - (k%32)]);
    for (int j = 0; j < 16; j++) tk(c[15-j]);
    tk(mode == 2 ? 1'b0 : 1'b1);
    chk(done && status == exp, mode == 0 ? "R9 R11 read ok" : "R11 read error", {done, status}, {1'b1, exp});
    chk(rx_dreq == 1'b1, "R2 dreq with data", rx_dreq, 1);
    @(negedge clk); start_rd = 1'b1;
    @(negedge clk); start_rd = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R3 read start ignored when not empty", busy, 0);
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      if (rx_rdata != wd[i]) err++;
      rx_rd = 1'b1;
    end
    @(negedge clk); rx_rd = 1'b0;
    chk(err == 0, "R10 R2 packed words", err, 0);
    chk(rx_dreq == 1'b0, "R2 dreq low when empty", rx_dreq, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_dreq && !rx_dreq && !busy && !dat_oe && !done, "R1 R2 reset state",
        {tx_dreq, rx_dreq, busy, dat_oe, done}, 5'b10000);
    start_wr = 1'b1;
    @(negedge clk); start_wr = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R3 write start ignored when not full", busy, 0);
    do_write(3'b010, 3, 5, 3'd0, 1'b1);
    do_write(3'b101, 0, 2, 3'd1, 1'b0);
    do_write(3'b111, 1, 0, 3'd2, 1'b0);
    do_write(3'b010, 2, 6, 3'd3, 1'b0);
    do_read(0, 10);
    do_read(1, 0);
    do_read(2, 2);
    @(negedge clk); start_rd = 1'b1;
    @(negedge clk); start_rd = 1'b0;
    begin
      int early = 0;
      for (int i = 0; i < 11; i++) begin
        tk(1'b1);
        if (i < 10 && done) early++;
      end
      chk(early == 0, "R9 no early timeout", early, 0);
    end
    chk(done && status == 3'd4, "R9 read timeout", {done, status}, {1'b1, 3'd4});
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule